// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command front end of a parallel NOR-style flash array model. It watches host write cycles on the address, data, write-enable and chip-enable pins. It recognises the unlock-prefixed command streams for a single-byte program and for a sector erase. It then runs a cycle-counted embedded operation that updates the array. The array is a plain register file held by the surrounding harness. The block reads the old byte at `arr_addr` and drives merged write data back, or pulses an erase request that carries a sector bitmap.

A bus write starts when both strobes are low and ends when either strobe goes high. The address is taken when the write starts, and the data byte when it ends. After an erase command, further sectors can be queued while a timed window is open. The window counts clock cycles without bus activity. When it expires, the erase starts. An erase can be suspended and resumed. Writes that arrive while a program operation runs are dropped. The active-low reset aborts everything and returns the decoder to read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy`, `load_open`, `suspended`, `arr_we` and `ers_we` are all 0, and the decoder is in read mode.
- R2: For each bus write, the address is sampled on the first clock where both `we_n` and `ce_n` are low. The data is sampled on the first clock where either strobe is high again. This holds whichever strobe falls last or rises first.
- R3: Each command starts with two unlock writes: data AAh at address 555h, then data 55h at address 2AAh. A wrong address or data in an unlock write, or an unknown command byte, returns the decoder to read mode without side effects.
- R4: After the unlock pair, data A0h at 555h arms a program. The next write supplies the target address and data, and `busy` goes high for PROG_CYC cycles.
- R5: When a program operation completes, `arr_we` pulses once with `arr_wdata` = old byte AND new byte. A bit can therefore only change from 1 to 0.
- R6: Every bus write received while a program operation runs is ignored.
- R7: Unlock, 80h at 555h, unlock, then data 30h opens the sector-load window (`load_open`=1). The sector is marked from the top log2(NSECT) address bits.
- R8: While the window is open, each further 30h write adds its sector and restarts the window. After WIN_CYC clock cycles with no bus write, the window closes and the erase starts (`busy`=1).
- R9: A write with any data other than 30h or B0h while the window is open closes it, discards the sector list and returns the decoder to read mode. Nothing is erased.
- R10: Data B0h written during the load window or during an erase suspends the erase (`suspended`=1, `busy`=0, progress held). Other writes are ignored while suspended. Data 30h resumes the erase.
- R11: When an erase completes, `ers_we` pulses once with `ers_mask` bit i set for each queued sector i. The harness then fills those sectors with FFh and leaves the other sectors untouched.
- R12: Asserting `rst_n` during a program operation aborts it. No array write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we_n | input | 1 | Write-enable strobe, active low |
| ce_n | input | 1 | Chip-enable strobe, active low |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| arr_rdata | input | DW | Array byte currently at `arr_addr` |
| arr_addr | output | AW | Program target address, for both read and write |
| arr_we | output | 1 | One-cycle program write to the array |
| arr_wdata | output | DW | Merged program data |
| ers_we | output | 1 | One-cycle erase request |
| ers_mask | output | NSECT | Sectors to erase |
| busy | output | 1 | Embedded program or erase running |
| load_open | output | 1 | Sector-load window open |
| suspended | output | 1 | Erase suspended |

## Verification
The assertions assume that the strobes and the bus are driven synchronously enough that each write spans at least one clock with both strobes low. They also assume that the harness returns `arr_rdata` for `arr_addr` in the same cycle. The bench drives every edge on the falling clock edge and holds the strobes low for two cycles. It scrambles address and data outside their sampling points, so a wrong capture instant would corrupt the array. Pauses between queued sector writes stay well under WIN_CYC, except where the bench lets the window expire on purpose.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PSET, ST_E1, ST_E2, ST_E3,
    ST_LOAD, ST_PBUSY, ST_EBUSY, ST_SUSP
  } seq_st_e;

  localparam logic [7:0] CD_UNLK1  = 8'hAA;
  localparam logic [7:0] CD_UNLK2  = 8'h55;
  localparam logic [7:0] CD_PROG   = 8'hA0;
  localparam logic [7:0] CD_ERSET  = 8'h80;
  localparam logic [7:0] CD_SECT   = 8'h30;
  localparam logic [7:0] CD_SUSP   = 8'hB0;
endpackage

// File: rtl/fcd_bus_cap.sv
module fcd_bus_cap #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_act,
  output logic          cyc_v,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data
);
  logic          act_q;
  logic [AW-1:0] addr_lat;

  assign wr_act = !we_n && !ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      addr_lat <= '0;
      cyc_v    <= 1'b0;
      cyc_addr <= '0;
      cyc_data <= '0;
    end else begin
      act_q <= wr_act;
      cyc_v <= act_q && !wr_act;
      if (wr_act && !act_q) addr_lat <= addr;   // later falling strobe
      if (act_q && !wr_act) begin               // earlier rising strobe
        cyc_addr <= addr_lat;
        cyc_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/fcd_engine.sv
module fcd_engine #(
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_p,
  input  logic run_e,
  input  logic hold,
  output logic done
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign done = (run_p && cnt == CW'(PROG_CYC - 1)) ||
                (run_e && cnt == CW'(ERASE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!(run_p || run_e || hold)) cnt <= '0;
    else if (run_p || run_e)           cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int NSECT   = 4,
  parameter int WIN_CYC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_act,
  input  logic             cyc_v,
  input  logic [AW-1:0]    cyc_addr,
  input  logic [DW-1:0]    cyc_data,
  input  logic             eng_done,
  output seq_st_e          state,
  output logic [NSECT-1:0] sect_mask,
  output logic [AW-1:0]    prog_addr,
  output logic [DW-1:0]    prog_data,
  output logic             win_exp
);
  localparam int SB = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam logic [AW-1:0] A_U1 = AW'('h555);
  localparam logic [AW-1:0] A_U2 = AW'('h2AA);

  logic [WW-1:0] wcnt;
  logic [7:0]    cd;
  logic          unl1, unl2, at_u1;
  logic [SB-1:0] sect;

  assign cd      = cyc_data[7:0];
  assign at_u1   = cyc_addr == A_U1;
  assign unl1    = at_u1 && cd == CD_UNLK1;
  assign unl2    = (cyc_addr == A_U2) && cd == CD_UNLK2;
  assign sect    = cyc_addr[AW-1 -: SB];
  assign win_exp = state == ST_LOAD && !cyc_v && !wr_act && wcnt == WW'(WIN_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_READ; sect_mask <= '0; wcnt <= '0;
      prog_addr <= '0; prog_data <= '0;
    end else begin
      case (state)
        ST_READ: begin
          sect_mask <= '0;
          if (cyc_v && unl1) state <= ST_U1;
        end
        ST_U1: if (cyc_v) state <= unl2 ? ST_U2 : ST_READ;
        ST_U2: if (cyc_v) begin
          if (at_u1 && cd == CD_PROG)       state <= ST_PSET;
          else if (at_u1 && cd == CD_ERSET) state <= ST_E1;
          else                              state <= ST_READ;
        end
        ST_PSET: if (cyc_v) begin
          prog_addr <= cyc_addr; prog_data <= cyc_data; state <= ST_PBUSY;
        end
        ST_E1: if (cyc_v) state <= unl1 ? ST_E2 : ST_READ;
        ST_E2: if (cyc_v) state <= unl2 ? ST_E3 : ST_READ;
        ST_E3: if (cyc_v) begin
          if (cd == CD_SECT) begin
            sect_mask[sect] <= 1'b1; wcnt <= '0; state <= ST_LOAD;
          end else state <= ST_READ;
        end
        ST_LOAD: begin
          if (cyc_v) begin
            if (cd == CD_SECT) begin sect_mask[sect] <= 1'b1; wcnt <= '0; end
            else if (cd == CD_SUSP) state <= ST_SUSP;
            else state <= ST_READ;
          end else if (win_exp) state <= ST_EBUSY;
          else if (!wr_act) wcnt <= wcnt + 1'b1;
        end
        ST_PBUSY: if (eng_done) state <= ST_READ;
        ST_EBUSY: begin
          if (eng_done) state <= ST_READ;
          else if (cyc_v && cd == CD_SUSP) state <= ST_SUSP;
        end
        ST_SUSP: if (cyc_v && cd == CD_SECT) state <= ST_EBUSY;
        default: state <= ST_READ;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int NSECT     = 4,
  parameter int WIN_CYC   = 24,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_n,
  input  logic             ce_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    arr_rdata,
  output logic [AW-1:0]    arr_addr,
  output logic             arr_we,
  output logic [DW-1:0]    arr_wdata,
  output logic             ers_we,
  output logic [NSECT-1:0] ers_mask,
  output logic             busy,
  output logic             load_open,
  output logic             suspended
);
  function automatic logic [DW-1:0] clear_merge(input logic [DW-1:0] old_b,
                                                input logic [DW-1:0] new_b);
    return old_b & new_b;
  endfunction

  logic          wr_act, cyc_v, eng_done, win_exp;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data, prog_data;
  seq_st_e       state;

  fcd_bus_cap #(.AW(AW), .DW(DW)) cap_i (
    .clk, .rst_n, .we_n, .ce_n, .addr, .wdata,
    .wr_act, .cyc_v, .cyc_addr, .cyc_data
  );

  fcd_seq #(.AW(AW), .DW(DW), .NSECT(NSECT), .WIN_CYC(WIN_CYC)) seq_i (
    .clk, .rst_n, .wr_act, .cyc_v, .cyc_addr, .cyc_data, .eng_done,
    .state, .sect_mask(ers_mask), .prog_addr(arr_addr), .prog_data, .win_exp
  );

  fcd_engine #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) eng_i (
    .clk, .rst_n,
    .run_p(state == ST_PBUSY), .run_e(state == ST_EBUSY),
    .hold(state == ST_SUSP), .done(eng_done)
  );

  assign busy      = state == ST_PBUSY || state == ST_EBUSY;
  assign load_open = state == ST_LOAD;
  assign suspended = state == ST_SUSP;
  assign arr_we    = eng_done && state == ST_PBUSY;
  assign ers_we    = eng_done && state == ST_EBUSY;
  assign arr_wdata = clear_merge(arr_rdata, prog_data);
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int DW    = 8,
  parameter int NSECT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             load_open,
  input logic             suspended,
  input logic             arr_we,
  input logic [DW-1:0]    arr_wdata,
  input logic [DW-1:0]    arr_rdata,
  input logic             ers_we,
  input logic [NSECT-1:0] ers_mask,
  input logic             cyc_v,
  input logic             win_exp
);
  a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ((arr_wdata & ~arr_rdata) == '0));

  a_r11_erase_has_sector: assert property (@(posedge clk) disable iff (!rst_n)
    ers_we |-> (ers_mask != '0) && busy);

  a_r1_exclusive_modes: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, load_open, suspended}));

  a_r10_suspend_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(cyc_v));

  a_r8_erase_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(load_open) && busy) |-> $past(win_exp));

  a_r4_done_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !busy && !load_open && !suspended);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.DW(DW), .NSECT(NSECT)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .load_open(load_open),
  .suspended(suspended), .arr_we(arr_we), .arr_wdata(arr_wdata),
  .arr_rdata(arr_rdata), .ers_we(ers_we), .ers_mask(ers_mask),
  .cyc_v(cyc_v), .win_exp(win_exp)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 11, DW = 8, NSECT = 4, WIN = 24, PC = 40, EC = 60;
  localparam int DEPTH = 1 << AW;
  localparam int SSZ = DEPTH / NSECT;

  logic clk = 1'b0, rst_n = 1'b0, we_n = 1'b1, ce_n = 1'b1;
  logic [AW-1:0] addr = '0, arr_addr;
  logic [DW-1:0] wdata = '0, arr_rdata, arr_wdata;
  logic arr_we, ers_we, busy, load_open, suspended;
  logic [NSECT-1:0] ers_mask;
  logic [7:0] mem [DEPTH];
  logic [7:0] expm [DEPTH];
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW), .NSECT(NSECT), .WIN_CYC(WIN),
    .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
    .clk, .rst_n, .we_n, .ce_n, .addr, .wdata, .arr_rdata, .arr_addr,
    .arr_we, .arr_wdata, .ers_we, .ers_mask, .busy, .load_open, .suspended);

  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) begin
    if (arr_we) mem[arr_addr] <= arr_wdata;
    if (ers_we)
      for (int i = 0; i < DEPTH; i++) if (ers_mask[i / SSZ]) mem[i] <= 8'hFF;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input bit o);
    @(negedge clk); wdata = ~d;
    if (o) begin ce_n = 1'b0; addr = ~a; @(negedge clk); end
    addr = a; we_n = 1'b0; ce_n = 1'b0;
    @(negedge clk); addr = ~a; wdata = d;
    @(negedge clk);
    if (o) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1; wdata = ~d;
    @(negedge clk);
  endtask

  task automatic unlock(input bit o);
    bus_wr(AW'('h555), 8'hAA, o);
    bus_wr(AW'('h2AA), 8'h55, o);
  endtask

  task automatic erase_cmd(input logic [AW-1:0] a);
    unlock(1'b0); bus_wr(AW'('h555), 8'h80, 1'b0);
    unlock(1'b1); bus_wr(a, 8'h30, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while ((busy || load_open) && k < 1000) begin @(negedge clk); k++; end
    idle(2);
    chk(k < 1000, tag, k, 0);
  endtask

  task automatic cmp_all(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, tag, bad, 0);
    if (bad != 0) $display("  first mismatch at %0h act=%0h exp=%0h",
                           first, mem[first], expm[first]);
  endtask

  task automatic erase_exp(input int s);
    for (int i = 0; i < SSZ; i++) expm[s * SSZ + i] = 8'hFF;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * 7) ^ 8'hC3; expm[i] = 8'(i * 7) ^ 8'hC3;
    end
    idle(3);
    chk(!busy && !load_open && !suspended, "R1 idle outputs", {busy, load_open, suspended}, 0);
    chk(!arr_we && !ers_we, "R1 no writes", {arr_we, ers_we}, 0);
    rst_n = 1'b1; idle(2);
    chk(!busy && !load_open && !suspended, "R1 after release", {busy, load_open, suspended}, 0);

    // R2 R4 R5: program sweep, both strobe orders, clear-only merge
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] a = AW'(k * 131 + 5);
      logic [7:0] d = 8'(8'h0F << (k % 5)) ^ 8'(k * 17);
      unlock(k[0]);
      bus_wr(AW'('h555), 8'hA0, k[1]);
      bus_wr(a, d, k[0] ^ k[1]);
      expm[a] = expm[a] & d;
      chk(busy, "R4 busy after program write", busy, 1);
      wait_idle("R4 program completes");
      chk(mem[a] == expm[a], "R5 merged byte", mem[a], expm[a]);
    end
    cmp_all("R2 capture sweep array");

    // R3: broken unlock sequences leave the array alone
    bus_wr(AW'('h555), 8'hAB, 1'b0); bus_wr(AW'('h2AA), 8'h55, 1'b0);
    bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h010), 8'h00, 1'b0);
    idle(PC + 5);
    chk(!busy, "R3 bad unlock1 data", busy, 0);
    bus_wr(AW'('h555), 8'hAA, 1'b0); bus_wr(AW'('h2AB), 8'h55, 1'b0);
    bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h011), 8'h00, 1'b0);
    idle(PC + 5);
    unlock(1'b0); bus_wr(AW'('h555), 8'h77, 1'b0);
    bus_wr(AW'('h012), 8'h00, 1'b0);
    idle(PC + 5);
    chk(!busy && !load_open, "R3 unknown cmd", {busy, load_open}, 0);
    cmp_all("R3 array untouched");
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h013), 8'h00, 1'b0);
    expm[AW'('h013)] = 8'h00;
    wait_idle("R3 recover");
    chk(mem[AW'('h013)] == 8'h00, "R3 valid after abort", mem[AW'('h013)], 0);

    // R6: writes during program ignored
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h020), 8'h81, 1'b0);
    expm[AW'('h020)] = expm[AW'('h020)] & 8'h81;
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h021), 8'h00, 1'b0);
    chk(busy, "R6 still busy", busy, 1);
    wait_idle("R6 done");
    chk(mem[AW'('h021)] == expm[AW'('h021)], "R6 ignored target", mem[AW'('h021)], expm[AW'('h021)]);
    cmp_all("R6 array");

    // R7 R8 R11: single sector erase
    erase_cmd(AW'(SSZ + 7));
    chk(load_open && !busy, "R7 window open", {load_open, busy}, 2);
    idle(WIN / 2);
    chk(load_open, "R8 window still open", load_open, 1);
    idle(WIN);
    chk(busy && !load_open, "R8 erase started after window", {busy, load_open}, 2);
    erase_exp(1);
    wait_idle("R11 erase done");
    cmp_all("R11 sector 1 erased");

    // R8: three sectors queued
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'(SSZ + 3), 8'h12, 1'b0);
    expm[SSZ + 3] = 8'h12; wait_idle("R8 prep");
    erase_cmd(AW'(9));
    bus_wr(AW'(3 * SSZ + 1), 8'h30, 1'b1);
    idle(WIN / 2);
    bus_wr(AW'(2 * SSZ), 8'h30, 1'b0);
    chk(load_open, "R8 window restarted", load_open, 1);
    erase_exp(0); erase_exp(2); erase_exp(3);
    wait_idle("R8 multi erase");
    cmp_all("R8 multi sector result");

    // R9: other command in window aborts
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'(2 * SSZ + 4), 8'h3C, 1'b0);
    expm[2 * SSZ + 4] = 8'h3C; wait_idle("R9 prep");
    erase_cmd(AW'(2 * SSZ));
    bus_wr(AW'('h000), 8'hF0, 1'b0);
    chk(!load_open && !busy, "R9 window closed", {load_open, busy}, 0);
    idle(WIN + EC + 10);
    chk(!busy, "R9 no erase", busy, 0);
    cmp_all("R9 array kept");

    // R10: suspend during erase, ignored writes, resume
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'(3 * SSZ + 8), 8'h44, 1'b0);
    expm[3 * SSZ + 8] = 8'h44; wait_idle("R10 prep");
    erase_cmd(AW'(3 * SSZ));
    idle(WIN + 5);
    chk(busy, "R10 erase running", busy, 1);
    bus_wr(AW'('h000), 8'hB0, 1'b0);
    chk(suspended && !busy, "R10 suspended", {suspended, busy}, 2);
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h030), 8'h00, 1'b0);
    idle(2 * EC);
    chk(suspended, "R10 stays suspended", suspended, 1);
    cmp_all("R10 array frozen");
    bus_wr(AW'('h000), 8'h30, 1'b0);
    chk(busy && !suspended, "R10 resumed", {busy, suspended}, 2);
    erase_exp(3);
    wait_idle("R10 resume done");
    cmp_all("R10 erased after resume");
    // suspend taken inside the load window
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'(5), 8'h01, 1'b0);
    expm[5] = 8'h01; wait_idle("R10 prep2");
    erase_cmd(AW'(1));
    bus_wr(AW'('h000), 8'hB0, 1'b0);
    chk(suspended && !load_open, "R10 suspend from window", {suspended, load_open}, 2);
    bus_wr(AW'('h000), 8'h30, 1'b0);
    erase_exp(0);
    wait_idle("R10 window resume");
    cmp_all("R10 window-suspend erase");

    // R12: reset aborts program
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h040), 8'h00, 1'b0);
    chk(busy, "R12 busy before reset", busy, 1);
    idle(5);
    rst_n = 1'b0; idle(2);
    chk(!busy && !arr_we, "R12 busy cleared", {busy, arr_we}, 0);
    rst_n = 1'b1; idle(PC + 10);
    chk(mem[AW'('h040)] == expm[AW'('h040)], "R12 no write", mem[AW'('h040)], expm[AW'('h040)]);
    unlock(1'b0); bus_wr(AW'('h555), 8'hA0, 1'b0); bus_wr(AW'('h040), 8'h00, 1'b0);
    expm[AW'('h040)] = 8'h00;
    wait_idle("R12 reprogram");
    cmp_all("R12 final array");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule